// File: doc/BRIEF.md
# Guard Soak Qualification Timer

This block turns bursty failure events from one reference channel's monitors into a steady disqualification flag. It works as a leaky integrator. Each clock cycle that carries an unmasked single-cycle-period failure or coarse-frequency failure raises an internal accumulator by one. While no unmasked failure is present, the accumulator falls by one for every `n` decay ticks. The flag `gst_fail_o` sets when the accumulator reaches the upper threshold. It clears only once the accumulator has drained to zero.

Both times come from one configuration word. The low field is the disqualification time `td`, given in failing clock cycles; it is also the upper threshold. The high field is the multiplier `n`. The qualification time is therefore `n * td` decay ticks, measured from a full accumulator. The block comes out of reset full and flagged, so a reference must soak clean for the whole qualification time before it is accepted.

Top module: `gst_soak_timer`

## Requirements
- R1: During and right after reset, `gst_fail_o` is 1 and the accumulator counts as full at the upper threshold.
- R2: On each clock where `scm_fail_i` or `cfm_fail_i` is 1 and its mask is 0, the accumulator rises by one. Starting from empty with sustained failure, `gst_fail_o` goes to 1 on the `td`-th failing clock.
- R3: The accumulator saturates at `td`. Any amount of failure beyond that still leaves exactly `n * td` decay ticks to clear the flag.
- R4: On clocks without unmasked failure, each `decay_tick_i` pulse advances a pacer. The accumulator drops by one on every `n`-th tick. A value of `n = 0` behaves as `n = 1`.
- R5: Once set, `gst_fail_o` stays at 1 at every nonzero accumulator value, including values rebuilt by later failures. It falls on the clock the accumulator reaches zero.
- R6: Once clear, `gst_fail_o` stays at 0 until the accumulator again reaches `td`.
- R7: A failure input whose mask bit (`scm_mask_i` or `cfm_mask_i`) is 1 counts as no failure, so decay continues.
- R8: A clock with unmasked failure resets the pacer, so any ticks collected toward the next decay step are discarded.
- R9: `soak_cfg_i[7:0]` is `td` in clock cycles, where 0 behaves as 1. `soak_cfg_i[11:8]` is `n`.
- R10: The accumulator stops at zero and never wraps. After a long clean period, reaching the flag takes exactly `td` failing clocks.
- R11: A decay tick that arrives on the same clock as an unmasked failure has no effect. The clock counts as a failure only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scm_fail_i | input | 1 | Single-cycle-period failure event for this clock |
| cfm_fail_i | input | 1 | Coarse-frequency failure event for this clock |
| scm_mask_i | input | 1 | 1 ignores `scm_fail_i` |
| cfm_mask_i | input | 1 | 1 ignores `cfm_fail_i` |
| decay_tick_i | input | 1 | Decay time base pulse |
| soak_cfg_i | input | 12 | {n[3:0], td[7:0]} |
| gst_fail_o | output | 1 | Disqualification flag |

## Verification
The stimulus patterns each separate one pair of behaviours:
- Sustained failure from empty distinguishes the rise time `td` from an off-by-one.
- A long overrun before release shows whether the accumulator saturates or keeps counting.
- Partial decay followed by short bursts separates hysteresis from a plain threshold compare.
- Masked event streams and ticks that coincide with failures show which inputs are allowed to move the accumulator.
- A failure placed between two sparse ticks reveals whether the pacer restarts.
- Setting `n = 0` exercises the floor on the rate.

A behavioural model in the bench is compared with `gst_fail_o` on every clock, alongside directed cycle counts.

// File: rtl/gst_soak_pkg.sv
package gst_soak_pkg;
  localparam int unsigned GST_TD_W  = 8;
  localparam int unsigned GST_N_W   = 4;
  localparam int unsigned GST_SRC_N = 2;

  // treat a zero setting as one
  function automatic logic [GST_TD_W-1:0] gst_min1_td(input logic [GST_TD_W-1:0] v);
    return (v == '0) ? GST_TD_W'(1) : v;
  endfunction
endpackage

// File: rtl/gst_fail_merge.sv
module gst_fail_merge #(
  parameter int unsigned SRC_N = gst_soak_pkg::GST_SRC_N
) (
  input  logic [SRC_N-1:0] evt_i,
  input  logic [SRC_N-1:0] mask_i,
  output logic             fail_o
);
  logic [SRC_N-1:0] live;

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    assign live[g] = evt_i[g] & ~mask_i[g];
  end

  assign fail_o = |live;
endmodule

// File: rtl/gst_decay_pacer.sv
module gst_decay_pacer #(
  parameter int unsigned N_W = gst_soak_pkg::GST_N_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           fail_i,
  input  logic           tick_i,
  input  logic [N_W-1:0] mult_i,
  output logic           step_o
);
  logic [N_W-1:0] cnt_q;
  logic [N_W-1:0] n_eff;
  logic           last;

  assign n_eff  = (mult_i == '0) ? N_W'(1) : mult_i;
  assign last   = ({1'b0, cnt_q} + (N_W+1)'(1)) >= {1'b0, n_eff};
  assign step_o = tick_i & ~fail_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (fail_i)          cnt_q <= '0;   // failure restarts pacing
    else if (tick_i && last)  cnt_q <= '0;
    else if (tick_i)          cnt_q <= cnt_q + N_W'(1);
  end

  assert_pace_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !fail_i && !step_o) |=> (cnt_q == $past(cnt_q) + N_W'(1)));

  assert_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> (cnt_q == '0));
endmodule

// File: rtl/gst_integrator.sv
module gst_integrator #(
  parameter int unsigned TD_W = gst_soak_pkg::GST_TD_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fail_i,
  input  logic            step_i,
  input  logic [TD_W-1:0] upper_i,
  output logic            gst_fail_o
);
  logic [TD_W-1:0] acc_q, acc_sat, acc_d;
  logic            flag_q;

  // reset value sits above any threshold; clamp brings it to upper
  assign acc_sat = (acc_q > upper_i) ? upper_i : acc_q;

  always_comb begin
    acc_d = acc_sat;
    if (fail_i) begin
      if (acc_sat < upper_i) acc_d = acc_sat + TD_W'(1);
    end else if (step_i) begin
      if (acc_sat != '0) acc_d = acc_sat - TD_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '1;
      flag_q <= 1'b1;
    end else begin
      acc_q <= acc_d;
      if (acc_d >= upper_i)  flag_q <= 1'b1;
      else if (acc_d == '0)  flag_q <= 1'b0;
    end
  end

  assign gst_fail_o = flag_q;

  assert_rise_on_fail_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(fail_i));

  assert_sat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> (acc_q <= $past(upper_i)) && (acc_q != '0));

  assert_fall_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> (acc_q == '0));

  assert_fall_on_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(step_i));

  assert_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fail_i && acc_sat == '0) |=> (acc_q == '0));
endmodule

// File: rtl/gst_soak_timer.sv
module gst_soak_timer
  import gst_soak_pkg::*;
#(
  parameter int unsigned TD_W = GST_TD_W,
  parameter int unsigned N_W  = GST_N_W,
  localparam int unsigned CFG_W = TD_W + N_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scm_fail_i,
  input  logic             cfm_fail_i,
  input  logic             scm_mask_i,
  input  logic             cfm_mask_i,
  input  logic             decay_tick_i,
  input  logic [CFG_W-1:0] soak_cfg_i,
  output logic             gst_fail_o
);
  logic            fail_any, step;
  logic [TD_W-1:0] td_raw, upper;
  logic [N_W-1:0]  mult;

  assign td_raw = soak_cfg_i[TD_W-1:0];
  assign mult   = soak_cfg_i[CFG_W-1:TD_W];
  assign upper  = (td_raw == '0) ? TD_W'(1) : td_raw;

  gst_fail_merge #(.SRC_N(2)) u_merge (
    .evt_i  ({cfm_fail_i, scm_fail_i}),
    .mask_i ({cfm_mask_i, scm_mask_i}),
    .fail_o (fail_any)
  );

  gst_decay_pacer #(.N_W(N_W)) u_pacer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fail_i (fail_any),
    .tick_i (decay_tick_i),
    .mult_i (mult),
    .step_o (step)
  );

  gst_integrator #(.TD_W(TD_W)) u_integ (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fail_i     (fail_any),
    .step_i     (step),
    .upper_i    (upper),
    .gst_fail_o (gst_fail_o)
  );

  assert_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scm_mask_i && cfm_mask_i && !gst_fail_o) |=> !gst_fail_o);

  assert_tick_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_any && gst_fail_o) |=> gst_fail_o);
endmodule

// File: tb/gst_soak_timer_bench.sv
module gst_soak_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scm = 1'b0, cfm = 1'b0, scm_m = 1'b0, cfm_m = 1'b0, tick = 1'b0;
  logic [11:0] cfg = {4'd2, 8'd4};
  logic        gst_fail;

  int    checks = 0, failures = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  gst_soak_timer u_gst_soak_timer (
    .clk_i(clk), .rst_ni(rst_n), .scm_fail_i(scm), .cfm_fail_i(cfm),
    .scm_mask_i(scm_m), .cfm_mask_i(cfm_m), .decay_tick_i(tick),
    .soak_cfg_i(cfg), .gst_fail_o(gst_fail));

  // behavioural reference
  int m_acc, m_cnt;
  bit m_flag;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 100000; m_cnt = 0; m_flag = 1'b1;
    end else begin
      int td, n, a;
      bit f;
      td = (cfg[7:0] == 0) ? 1 : int'(cfg[7:0]);
      n  = (cfg[11:8] == 0) ? 1 : int'(cfg[11:8]);
      a  = (m_acc > td) ? td : m_acc;
      f  = (scm && !scm_m) || (cfm && !cfm_m);
      if (f) begin
        if (a < td) a++;
        m_cnt = 0;
      end else if (tick) begin
        if (m_cnt + 1 >= n) begin
          m_cnt = 0;
          if (a > 0) a--;
        end else m_cnt++;
      end
      m_acc = a;
      if (a >= td) m_flag = 1'b1;
      else if (a == 0) m_flag = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (gst_fail !== m_flag) begin
        failures++;
        $display("FAIL %s model compare: actual=%b expected=%b", cur_req, gst_fail, m_flag);
      end
    end
  end

  task automatic expect_val(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit s, input bit c, input bit t);
    scm = s; cfm = c; tick = t;
    @(posedge clk); #1;
  endtask

  task automatic ticks_to_clear(output int k);
    k = 0;
    while (gst_fail && k < 500) begin
      cyc(1'b0, 1'b0, 1'b1);
      k++;
    end
  endtask

  initial begin
    int k;
    repeat (3) @(posedge clk);
    #1;
    expect_val(int'(gst_fail), 1, "R1");
    rst_n = 1'b1;
    @(posedge clk); #1;
    expect_val(int'(gst_fail), 1, "R1");

    cur_req = "R4";  // td=4 n=2 from full
    ticks_to_clear(k);
    expect_val(k, 8, "R4 R9 qualification td*n");

    cur_req = "R2";
    repeat (3) cyc(1'b1, 1'b0, 1'b1);
    expect_val(int'(gst_fail), 0, "R2 before td");
    cyc(1'b1, 1'b0, 1'b1);
    expect_val(int'(gst_fail), 1, "R2 R11 at td");
    cur_req = "R3";
    repeat (20) cyc(1'b1, 1'b0, 1'b1);
    ticks_to_clear(k);
    expect_val(k, 8, "R3 saturation");

    cur_req = "R4";  // n=0 acts as 1
    cfg = {4'd0, 8'd4};
    repeat (4) cyc(1'b1, 1'b0, 1'b0);
    ticks_to_clear(k);
    expect_val(k, 4, "R4 n=0");

    cur_req = "R7";
    cfg = {4'd1, 8'd4};
    scm_m = 1'b1;
    repeat (10) cyc(1'b1, 1'b0, 1'b0);
    expect_val(int'(gst_fail), 0, "R7 masked scm");
    cur_req = "R2";
    repeat (4) cyc(1'b1, 1'b1, 1'b0);
    expect_val(int'(gst_fail), 1, "R2 cfm source");
    cur_req = "R7";
    cfm_m = 1'b1;
    repeat (3) cyc(1'b1, 1'b1, 1'b1);
    expect_val(int'(gst_fail), 1, "R7 partial decay");
    cyc(1'b1, 1'b1, 1'b1);
    expect_val(int'(gst_fail), 0, "R7 masked both decays");
    scm_m = 1'b0; cfm_m = 1'b0;

    cur_req = "R5";
    repeat (4) cyc(1'b1, 1'b0, 1'b0);
    repeat (3) cyc(1'b0, 1'b0, 1'b1);
    expect_val(int'(gst_fail), 1, "R5 held at 1");
    repeat (2) cyc(1'b0, 1'b1, 1'b0);
    expect_val(int'(gst_fail), 1, "R5 rebuilt");
    ticks_to_clear(k);
    expect_val(k, 3, "R5 clears at zero");
    cur_req = "R6";
    repeat (3) cyc(1'b1, 1'b0, 1'b0);
    expect_val(int'(gst_fail), 0, "R6 stays clear below td");
    cyc(1'b0, 1'b0, 1'b1);
    expect_val(int'(gst_fail), 0, "R6 clear on decay");

    cur_req = "R8";
    cfg = {4'd3, 8'd2};
    repeat (3) cyc(1'b1, 1'b0, 1'b0);
    repeat (2) cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b0);
    ticks_to_clear(k);
    expect_val(k, 6, "R8 pacer restart");

    cur_req = "R10";
    repeat (20) cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b0);
    expect_val(int'(gst_fail), 0, "R10 one after floor");
    cyc(1'b1, 1'b0, 1'b0);
    expect_val(int'(gst_fail), 1, "R10 td after floor");

    cur_req = "R9";  // td field 0 acts as 1
    cfg = {4'd1, 8'd0};
    ticks_to_clear(k);
    expect_val(k, 1, "R9 td=0");
    cyc(1'b1, 1'b0, 1'b0);
    expect_val(int'(gst_fail), 1, "R9 td=0 rise");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1'b1;
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule